// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block gathers single-cycle event pulses from on-chip sources into a 32-bit sticky cause register, together with a second sticky register for DMA channel events. From these it drives one level-sensitive host interrupt line. An enable register selects which causes may raise the line. A hold-off timer delays the line after the first enabled cause so that several events can be serviced in one pass. The hold-off is counted in 32 µs units. A high-priority receive event skips the hold-off. The second byte of the timer word sets a periodic receive timer, which sets its own cause bit.

DMA events are also folded into three summary causes in the main register: receive, transmit and error. The host uses a plain word-addressed register port. There is no back-pressure: every write takes effect at the clock edge where it is presented, and read data is combinational from the address. The 32 µs tick comes from a prescaler sized by the core clock frequency parameter.

Top module: `host_irq_coalescer`

## Requirements
- R1: Writing a word to address 0 (main causes) or address 3 (DMA causes) clears each bit written as 1. Bits written as 0 are left unchanged.
- R2: If a clear and a new event hit the same bit in the same cycle, the bit ends up set.
- R3: In the main register, only bits 26, 25, 7, 6, 1 and 0 latch from `src_evt`. In the DMA register, only bits 31, 30, 17, 16, 1 and 0 latch from `dma_evt`. Pulses on any other position leave both registers unchanged.
- R4: A DMA event on bit 30, 17 or 16 sets main bit 31. A DMA event on bit 1 or 0 sets main bit 27. A DMA event on bit 31 sets main bit 29. Each summary bit is set in the same cycle as the DMA bit.
- R5: When the hold-off byte (address 2, bits 7:0) is 0, `irq_o` equals the OR of (causes AND enables) after each edge. It is a level, and it drops once every enabled cause is cleared.
- R6: A cause whose enable bit (address 1) is 0 never raises `irq_o`. Setting that enable bit later raises `irq_o` while the cause is still pending.
- R7: With a hold-off byte D ≠ 0, `irq_o` rises exactly D×TICK_CYC cycles after the first enabled cause is latched, and then stays high while any enabled cause is pending. The count starts again once all enabled causes have been cleared.
- R8: A DMA event on bit 30, with main enable bit 31 set, raises `irq_o` after the same edge that latches it, whatever the hold-off value.
- R9: With a periodic byte (address 2, bits 15:8) P ≠ 0, main bit 28 is set once every P ticks. With P = 0 it is never set.
- R10: Address map: 0 main causes, 1 enables, 2 timer word (bits 15:0 stored, bits 31:16 read 0), 3 DMA causes. After reset every register is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 32 | Event pulses for the main cause register |
| dma_evt | input | 32 | Event pulses for the DMA cause register |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Host interrupt level |

## Verification
The assertions take the inputs as two-state and synchronous to `clk`. They also assume that a register write is a single-cycle strobe with a stable address. Because the event inputs are treated as pulses, a clear without a matching event must never raise a bit.

The stimulus drives every input at the falling edge and holds each event and each write for exactly one cycle. Coalescing is timed with a shortened tick, so a count of several ticks fits in a short run.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int REG_W = 32;

  localparam logic [1:0] A_MAIN = 2'd0;
  localparam logic [1:0] A_ENA  = 2'd1;
  localparam logic [1:0] A_TMR  = 2'd2;
  localparam logic [1:0] A_DMA  = 2'd3;

  localparam int B_RX_SUM   = 31;
  localparam int B_ERR_SUM  = 29;
  localparam int B_PERIODIC = 28;
  localparam int B_TX_SUM   = 27;
  localparam int B_DMA_ERR  = 31;
  localparam int B_DMA_HP   = 30;

  localparam logic [REG_W-1:0] SRC_KEEP  = 32'h0600_00C3;
  localparam logic [REG_W-1:0] MAIN_KEEP = SRC_KEEP | 32'hB800_0000;
  localparam logic [REG_W-1:0] DMA_KEEP  = 32'hC003_0003;
  localparam logic [REG_W-1:0] DMA_RX    = 32'h4003_0000;
  localparam logic [REG_W-1:0] DMA_TX    = 32'h0000_0003;
endpackage

// File: rtl/hirq_w1c_reg.sv
module hirq_w1c_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= ((q & ~clr) | evt) & KEEP;
  end

  // R2: an event always leaves its bit set, clear or not
  a_r2_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & KEEP)) |=> ((q & $past(evt & KEEP)) == $past(evt & KEEP)));

  // R1: bits only fall when a clear was presented
  a_r1_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/hirq_tick_gen.sv
module hirq_tick_gen #(
  parameter int TICK_CYC = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] period,
  output logic       per_pulse
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

  logic [PW-1:0] pre_q;
  logic          tick;
  logic [7:0]    per_q;

  assign tick = (pre_q == PW'(TICK_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || tick) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q     <= '0;
      per_pulse <= 1'b0;
    end else if (period == 8'd0) begin
      per_q     <= '0;
      per_pulse <= 1'b0;
    end else if (tick && (per_q + 8'd1 >= period)) begin
      per_q     <= '0;
      per_pulse <= 1'b1;
    end else begin
      if (tick) per_q <= per_q + 8'd1;
      per_pulse <= 1'b0;
    end
  end

  // R9: a zero period keeps the periodic cause silent
  a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (period == 8'd0) |=> !per_pulse);

  // R9: periodic pulses are single-cycle
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |=> !per_pulse);
endmodule

// File: rtl/hirq_coalesce.sv
module hirq_coalesce #(
  parameter int TICK_CYC = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pending,
  input  logic [7:0] delay,
  input  logic       hp_fire,
  output logic       irq_o
);
  localparam int CW = $clog2(255 * TICK_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          open_q;

  assign limit = CW'(delay) * CW'(TICK_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (hp_fire) begin
      open_q <= 1'b1;
    end else if (!pending) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (!open_q) begin
      if (cnt_q + 1'b1 >= limit) open_q <= 1'b1;
      else                       cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign irq_o = pending & (open_q | (delay == 8'd0));

  // R8: a high-priority event opens the gate on the next cycle
  a_r8_hp_opens: assert property (@(posedge clk) disable iff (!rst_n)
    hp_fire |=> open_q);

  // R7: the gate closes once nothing enabled is pending
  a_r7_idle_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !hp_fire) |=> (!open_q && cnt_q == '0));
endmodule

// File: rtl/host_irq_coalescer.sv
module host_irq_coalescer
  import hirq_pkg::*;
#(
  parameter int CLK_MHZ = 250,
  parameter int TICK_NS = 32000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_evt,
  input  logic [31:0] dma_evt,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o
);
  localparam int TICK_CYC = (CLK_MHZ * TICK_NS) / 1000;

  logic [REG_W-1:0] main_q, dma_q, ena_q;
  logic [REG_W-1:0] main_evt, main_clr, dma_in, dma_clr;
  logic [15:0]      tmr_q;
  logic             per_pulse, hp_fire, pending;

  assign dma_in = dma_evt & DMA_KEEP;

  always_comb begin
    main_evt             = src_evt & SRC_KEEP;
    main_evt[B_RX_SUM]   = |(dma_in & DMA_RX);
    main_evt[B_TX_SUM]   = |(dma_in & DMA_TX);
    main_evt[B_ERR_SUM]  = dma_in[B_DMA_ERR];
    main_evt[B_PERIODIC] = per_pulse;
  end

  assign main_clr = (reg_we && reg_addr == A_MAIN) ? reg_wdata : '0;
  assign dma_clr  = (reg_we && reg_addr == A_DMA)  ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q <= '0;
      tmr_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_ENA) ena_q <= reg_wdata;
      if (reg_addr == A_TMR) tmr_q <= reg_wdata[15:0];
    end
  end

  hirq_w1c_reg #(.W(REG_W), .KEEP(MAIN_KEEP)) u_main (
    .clk(clk), .rst_n(rst_n), .evt(main_evt), .clr(main_clr), .q(main_q));

  hirq_w1c_reg #(.W(REG_W), .KEEP(DMA_KEEP)) u_dma (
    .clk(clk), .rst_n(rst_n), .evt(dma_in), .clr(dma_clr), .q(dma_q));

  hirq_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .period(tmr_q[15:8]), .per_pulse(per_pulse));

  assign hp_fire = dma_in[B_DMA_HP] & ena_q[B_RX_SUM];
  assign pending = |(main_q & ena_q);

  hirq_coalesce #(.TICK_CYC(TICK_CYC)) u_coal (
    .clk(clk), .rst_n(rst_n), .pending(pending), .delay(tmr_q[7:0]),
    .hp_fire(hp_fire), .irq_o(irq_o));

  always_comb begin
    case (reg_addr)
      A_MAIN:  reg_rdata = main_q;
      A_ENA:   reg_rdata = ena_q;
      A_TMR:   reg_rdata = {16'd0, tmr_q};
      default: reg_rdata = dma_q;
    endcase
  end

  // R4: a receive-side DMA event shows up in the summary bit
  a_r4_rx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dma_in & DMA_RX)) |=> main_q[B_RX_SUM]);

  // R8: bypass reaches the pin one edge after the event
  a_r8_bypass_pin: assert property (@(posedge clk) disable iff (!rst_n)
    hp_fire |=> irq_o);

  // R6: nothing enabled and pending means a quiet line
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_q & ena_q) == '0) |-> !irq_o);
endmodule

// File: tb/host_irq_coalescer_bench.sv
`timescale 1ns/1ps
module host_irq_coalescer_bench;
  localparam int TICK = 16;  // 250 MHz x 64 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] src_evt = '0, dma_evt = '0, reg_wdata = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_rdata;
  logic irq_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  host_irq_coalescer #(.CLK_MHZ(250), .TICK_NS(64)) u_host_irq_coalescer (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .dma_evt(dma_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(logic [31:0] s, logic [31:0] dm);
    @(negedge clk); src_evt = s; dma_evt = dm;
    @(negedge clk); src_evt = '0; dma_evt = '0;
  endtask

  task automatic clear_all();
    wr(2'd0, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R10 reset reg", v, 0); end
    chk("R10 reset irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(2'd1, 32'hA5A5_5A5A); rd(2'd1, v); chk("R10 enable readback", v, 32'hA5A5_5A5A);
    wr(2'd2, 32'hFFFF_1234); rd(2'd2, v); chk("R10 timer readback", v, 32'h0000_1234);
    wr(2'd2, 0); wr(2'd1, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    pulse(32'h0600_0003, 0); rd(2'd0, v); chk("R1 set", v, 32'h0600_0003);
    wr(2'd0, 32'h0000_0000); rd(2'd0, v); chk("R1 zero write", v, 32'h0600_0003);
    wr(2'd0, 32'h0400_0001); rd(2'd0, v); chk("R1 partial clear", v, 32'h0200_0002);
    clear_all();
  endtask

  task automatic t_event_wins();
    logic [31:0] v;
    pulse(32'h40, 0);
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h40; src_evt = 32'h40;
    @(negedge clk); reg_we = 1'b0; src_evt = 0;
    rd(2'd0, v); chk("R2 event beats clear", v, 32'h40);
    clear_all();
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    pulse(32'h0100_0F3C, 32'h0004_F0F0); // positions outside the kept sets
    rd(2'd0, v); chk("R3 main ignored", v, 0);
    rd(2'd3, v); chk("R3 dma ignored", v, 0);
  endtask

  task automatic t_summary();
    logic [31:0] v;
    pulse(0, 32'h1); rd(2'd0, v); chk("R4 tx summary", v, 32'h0800_0000);
    rd(2'd3, v); chk("R4 dma tx bit", v, 32'h1);
    clear_all();
    pulse(0, 32'h8000_0000); rd(2'd0, v); chk("R4 err summary", v, 32'h2000_0000);
    clear_all();
    pulse(0, 32'h0002_0000); rd(2'd0, v); chk("R4 rx summary", v, 32'h8000_0000);
    clear_all();
  endtask

  task automatic t_mask();
    pulse(32'h40, 0);
    chk("R6 masked quiet", {31'd0, irq_o}, 0);
    wr(2'd1, 32'h40);
    chk("R6 enable raises", {31'd0, irq_o}, 1);
    wr(2'd0, 32'h40);
    chk("R5 level drops", {31'd0, irq_o}, 0);
    pulse(32'h2, 0);
    chk("R5 other bit masked", {31'd0, irq_o}, 0);
    wr(2'd1, 32'h42);
    chk("R5 or of enabled", {31'd0, irq_o}, 1);
    clear_all(); wr(2'd1, 0);
  endtask

  task automatic t_coalesce();
    wr(2'd2, 32'h2); wr(2'd1, 32'h1);
    for (int rep = 0; rep < 2; rep++) begin
      pulse(32'h1, 0);
      repeat (2*TICK - 1) @(negedge clk);
      chk("R7 held off", {31'd0, irq_o}, 0);
      @(negedge clk);
      chk("R7 released", {31'd0, irq_o}, 1);
      repeat (5) @(negedge clk);
      chk("R7 stays high", {31'd0, irq_o}, 1);
      wr(2'd0, 32'h1);
      chk("R7 drops on clear", {31'd0, irq_o}, 0);
    end
  endtask

  task automatic t_bypass();
    logic [31:0] v;
    wr(2'd1, 32'h8000_0000);
    pulse(0, 32'h4000_0000);
    chk("R8 bypass immediate", {31'd0, irq_o}, 1);
    rd(2'd3, v); chk("R8 dma hp bit", v, 32'h4000_0000);
    clear_all();
    chk("R8 drops", {31'd0, irq_o}, 0);
    wr(2'd1, 0); wr(2'd2, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(2'd2, 32'h0000_0200);
    repeat (3*TICK + 8) @(negedge clk);
    rd(2'd0, v); chk("R9 periodic set", v & 32'h1000_0000, 32'h1000_0000);
    wr(2'd0, 32'h1000_0000);
    repeat (3*TICK + 8) @(negedge clk);
    rd(2'd0, v); chk("R9 periodic repeats", v & 32'h1000_0000, 32'h1000_0000);
    wr(2'd2, 0); wr(2'd0, 32'hFFFF_FFFF);
    repeat (10*TICK) @(negedge clk);
    rd(2'd0, v); chk("R9 disabled", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_w1c();
    t_event_wins();
    t_ignored();
    t_summary();
    t_mask();
    t_coalesce();
    t_bypass();
    t_periodic();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule